// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Bridge

This block gives a host a plain memory window onto a bank of serial NOR flash devices. A host read inside a bank's window becomes a complete read transaction on the serial port: a read opcode, the 24-bit byte address sent most significant byte first, an optional dummy byte when fast reads are selected, and then as many data bytes as the host enabled. The bytes come back into the host's data lanes. A host write becomes a page-program transaction. The write is allowed only when the flash on that bank has its write-enable latch set, which the surrounding controller reports on a per-bank input.

When burst mode is selected, writes are merged. Each write that continues at the next byte address with the same access size extends the open page program, and chip select stays low. The burst closes on any non-sequential write, on a size change, on a read, or when burst mode or hardware mode is withdrawn. Closing the burst raises chip select and reports write completion. While the controller is in software mode the window is closed: requests are taken and dropped, and they are flagged as forbidden accesses.

The host request and the read response are both valid/ready streams. A request is taken on a cycle where `req_valid` and `req_ready` are both high, and the requester must hold its fields stable until then. A read response is presented with `rsp_valid` until `rsp_ready` is seen, and `rsp_data` does not change while it waits. No new request is taken while a response is pending. Writes produce no response.

Top module: `flash_mm_bridge`

## Requirements
- R1: After reset every chip select is high, the serial clock is low, no response is pending and no event is raised. `req_ready` rises once the deselect gap has elapsed.
- R2: A host read with fast mode off sends opcode 0x03 and the byte address, most significant byte first. The address is the word address with the lowest enabled lane appended. The flash then returns one byte per enabled lane. These bytes fill the enabled lanes in ascending lane order, and the other lanes read zero.
- R3: A host read with fast mode on sends opcode 0x0B, the address, and one dummy byte of 0x00 whose returned value is discarded, before the data bytes.
- R4: A host write with burst mode off sends opcode 0x02, the address, and the enabled lanes' bytes in ascending lane order. Chip select then rises, and `evt_wr_done` pulses for one cycle at the moment it rises.
- R5: In burst mode, a write to the same bank whose first byte address equals the previous end address and whose enabled-lane count is unchanged is appended to the open program. Only its data bytes are sent, and chip select stays low.
- R6: In burst mode, a write that is not sequential or has a different size first closes the open program (chip select high, `evt_wr_done`). It then starts a new program command.
- R7: Clearing burst mode while a program is open closes it, with no request needed.
- R8: A write to a bank whose write-enable input is low is dropped. No chip select falls, and `evt_bad_write` pulses.
- R9: While software mode is set, every request is taken and dropped without serial activity, and `evt_bad_access` pulses. A read then returns zero data.
- R10: The bank field above the 24-bit flash address selects which chip select falls. At most one chip select is low at any time.
- R11: Between transactions, chip select stays high for at least `CS_GAP` clock cycles.
- R12: The serial port runs in clock mode 0. `spi_mosi` changes only while `spi_sck` is low, and `spi_sck` is low whenever no chip select is active.
- R13: A pending read response keeps `rsp_valid` high and `rsp_data` unchanged until `rsp_ready`. `req_ready` stays low while it is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_mode | input | 1 | Controller in software mode; the memory window is closed |
| wburst_mode | input | 1 | Merge sequential same-size writes into one program |
| fast_mode | input | 1 | Use the fast read opcode with a dummy byte |
| wel_bank | input | NB | Write-enable latch state per bank |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request taken this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24+log2(NB)-log2(DATA_W/8) | Word address: bank field on top, flash word address below |
| req_be | input | DATA_W/8 | Byte-lane enables (contiguous, nonzero) |
| req_wdata | input | DATA_W | Write data by lane |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response taken |
| rsp_data | output | DATA_W | Read data by lane |
| evt_wr_done | output | 1 | One-cycle pulse when a program transaction closes |
| evt_bad_write | output | 1 | One-cycle pulse on a write dropped for missing write enable |
| evt_bad_access | output | 1 | One-cycle pulse on a request dropped in software mode |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | NB | Active-low chip selects, one per bank |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The hardest state to reach from the ports is a burst that is held open with chip select low between two host writes, and then closed by each of its three separate causes. The bench turns burst mode on and issues two back-to-back sequential word writes, so the second is accepted only while the first program is still open. It then follows them with a write that jumps in address, then a sequential write of a different size, and finally withdraws burst mode with no request present. A flash model captures every byte on the serial port and counts chip-select falls, so merging shows up as a missing second header and a single transaction.

// File: rtl/smb_pkg.sv
package smb_pkg;

  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_FAST  = 8'h0B;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] DUMMY_TX = 8'h00;

  localparam int ADDR_BYTES = 3;
  localparam int FA_W       = 8 * ADDR_BYTES;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_OPEN,
    ST_RESP
  } seq_state_e;

  // number of set bits in a lane mask (up to 16 lanes)
  function automatic logic [4:0] count_set(input logic [15:0] v);
    logic [4:0] r;
    r = '0;
    for (int i = 0; i < 16; i++) r = r + {4'd0, v[i]};
    return r;
  endfunction

  // index of the lowest set bit of a lane mask
  function automatic logic [3:0] low_set(input logic [15:0] v);
    logic [3:0] r;
    r = '0;
    for (int i = 15; i >= 0; i--) if (v[i]) r = 4'(i);
    return r;
  endfunction

endpackage

// File: rtl/smb_shift.sv
module smb_shift #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rx_word,
  output logic              sck,
  output logic              mosi
);
  localparam int PH_N = 2 * WORD_W;
  localparam int PH_W = $clog2(PH_N);

  logic [WORD_W-1:0] sh_q, rx_q;
  logic [PH_W-1:0]   ph_q;
  logic              busy_q, sck_q, done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      rx_q   <= '0;
      ph_q   <= '0;
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        busy_q <= 1'b1;
        sh_q   <= tx_word;
        ph_q   <= '0;
        sck_q  <= 1'b0;
      end else if (busy_q) begin
        if (!ph_q[0]) begin
          sck_q <= 1'b1;                       // rising edge: flash samples
        end else begin
          sck_q <= 1'b0;                       // falling edge: sample, shift
          sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
          rx_q  <= {rx_q[WORD_W-2:0], miso};
        end
        ph_q <= ph_q + 1'b1;
        if (ph_q == PH_W'(PH_N - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_word = rx_q;
  assign sck     = sck_q;
  assign mosi    = sh_q[WORD_W-1];

endmodule

// File: rtl/smb_seq.sv
module smb_seq
  import smb_pkg::*;
#(
  parameter int NB     = 4,
  parameter int DATA_W = 32,
  parameter int CS_GAP = 4
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         sw_mode,
  input  logic                                         wburst_mode,
  input  logic                                         fast_mode,
  input  logic [NB-1:0]                                wel_bank,
  input  logic                                         req_valid,
  output logic                                         req_ready,
  input  logic                                         req_write,
  input  logic [FA_W+$clog2(NB)-$clog2(DATA_W/8)-1:0]  req_addr,
  input  logic [DATA_W/8-1:0]                          req_be,
  input  logic [DATA_W-1:0]                            req_wdata,
  output logic                                         rsp_valid,
  input  logic                                         rsp_ready,
  output logic [DATA_W-1:0]                            rsp_data,
  output logic                                         evt_wr_done,
  output logic                                         evt_bad_write,
  output logic                                         evt_bad_access,
  output logic                                         sh_start,
  output logic [7:0]                                   sh_tx,
  input  logic                                         sh_busy,
  input  logic                                         sh_done,
  input  logic [7:0]                                   sh_rx,
  output logic                                         cs_act,
  output logic [$clog2(NB)-1:0]                        cs_bank
);
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int BANK_W = $clog2(NB);
  localparam int CNT_W  = $clog2(LANES + 1);
  localparam int GAP_W  = $clog2(CS_GAP + 1);
  localparam int HDR_MX = 1 + ADDR_BYTES + 1;
  localparam int IDX_W  = $clog2(HDR_MX + LANES + 1);
  localparam int WA_W   = FA_W + BANK_W - LANE_W;

  seq_state_e         state_q;
  logic [BANK_W-1:0]  bank_q;
  logic               write_q, fast_q, cs_q, inflight_q;
  logic [CNT_W-1:0]   n_q;
  logic [LANE_W-1:0]  lane0_q;
  logic [FA_W-1:0]    fa_q, next_fa_q;
  logic [DATA_W-1:0]  wdata_q, rdata_q;
  logic [IDX_W-1:0]   idx_q;
  logic [GAP_W-1:0]   gap_q;
  logic               wd_q, bw_q, ba_q;

  // request decode
  logic [BANK_W-1:0]  req_bank;
  logic [CNT_W-1:0]   req_n;
  logic [LANE_W-1:0]  req_lane;
  logic [FA_W-1:0]    req_fa;
  logic               gap_ok, seq_hit, accept;

  assign req_bank = req_addr[WA_W-1 -: BANK_W];
  assign req_n    = CNT_W'(count_set(16'(req_be)));
  assign req_lane = LANE_W'(low_set(16'(req_be)));
  assign req_fa   = {req_addr[FA_W-LANE_W-1:0], req_lane};
  assign gap_ok   = (gap_q >= GAP_W'(CS_GAP));

  assign seq_hit = req_valid && req_write && wburst_mode && !sw_mode &&
                   (req_bank == bank_q) && (req_fa == next_fa_q) &&
                   (req_n == n_q);

  assign req_ready = ((state_q == ST_IDLE) && gap_ok) ||
                     ((state_q == ST_OPEN) && seq_hit);
  assign accept    = req_valid && req_ready;

  // byte sequencing
  logic [IDX_W-1:0]  hdr_len, last_idx;
  logic [LANE_W-1:0] cur_lane;
  logic              in_data;

  assign hdr_len  = (!write_q && fast_q) ? IDX_W'(HDR_MX) : IDX_W'(HDR_MX - 1);
  assign last_idx = hdr_len + IDX_W'(n_q) - 1'b1;
  assign in_data  = (idx_q >= hdr_len);
  assign cur_lane = lane0_q + LANE_W'(idx_q - hdr_len);

  always_comb begin
    if (idx_q == '0) begin
      sh_tx = write_q ? OP_PROG : (fast_q ? OP_FAST : OP_READ);
    end else if (idx_q <= IDX_W'(ADDR_BYTES)) begin
      sh_tx = fa_q[8*(ADDR_BYTES - int'(idx_q)) +: 8];
    end else if (in_data && write_q) begin
      sh_tx = wdata_q[{cur_lane, 3'b000} +: 8];
    end else begin
      sh_tx = DUMMY_TX;
    end
  end

  assign sh_start = (state_q == ST_XFER) && !inflight_q && !sh_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      bank_q     <= '0;
      write_q    <= 1'b0;
      fast_q     <= 1'b0;
      cs_q       <= 1'b0;
      inflight_q <= 1'b0;
      n_q        <= '0;
      lane0_q    <= '0;
      fa_q       <= '0;
      next_fa_q  <= '0;
      wdata_q    <= '0;
      rdata_q    <= '0;
      idx_q      <= '0;
      gap_q      <= '0;
      wd_q       <= 1'b0;
      bw_q       <= 1'b0;
      ba_q       <= 1'b0;
    end else begin
      wd_q <= 1'b0;
      bw_q <= 1'b0;
      ba_q <= 1'b0;

      if (cs_q)        gap_q <= '0;
      else if (!gap_ok) gap_q <= gap_q + 1'b1;

      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            bank_q    <= req_bank;
            write_q   <= req_write;
            fast_q    <= fast_mode;
            n_q       <= req_n;
            lane0_q   <= req_lane;
            fa_q      <= req_fa;
            next_fa_q <= req_fa + FA_W'(req_n);
            wdata_q   <= req_wdata;
            rdata_q   <= '0;
            idx_q     <= '0;
            if (sw_mode) begin
              ba_q <= 1'b1;
              if (!req_write) state_q <= ST_RESP;
            end else if (req_write && !wel_bank[req_bank]) begin
              bw_q <= 1'b1;
            end else begin
              cs_q    <= 1'b1;
              state_q <= ST_XFER;
            end
          end
        end

        ST_XFER: begin
          if (sh_start) inflight_q <= 1'b1;
          if (sh_done) begin
            inflight_q <= 1'b0;
            if (!write_q && in_data)
              rdata_q[{cur_lane, 3'b000} +: 8] <= sh_rx;
            if (idx_q == last_idx) begin
              if (!write_q) begin
                cs_q    <= 1'b0;
                state_q <= ST_RESP;
              end else if (wburst_mode && !sw_mode) begin
                state_q <= ST_OPEN;
              end else begin
                cs_q    <= 1'b0;
                wd_q    <= 1'b1;
                state_q <= ST_IDLE;
              end
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end

        ST_OPEN: begin
          if (accept) begin
            wdata_q   <= req_wdata;
            lane0_q   <= req_lane;
            next_fa_q <= next_fa_q + FA_W'(req_n);
            idx_q     <= IDX_W'(HDR_MX - 1);
            state_q   <= ST_XFER;
          end else if (!wburst_mode || sw_mode || req_valid) begin
            cs_q    <= 1'b0;
            wd_q    <= 1'b1;
            state_q <= ST_IDLE;
          end
        end

        ST_RESP: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end

        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid      = (state_q == ST_RESP);
  assign rsp_data       = rdata_q;
  assign evt_wr_done    = wd_q;
  assign evt_bad_write  = bw_q;
  assign evt_bad_access = ba_q;
  assign cs_act         = cs_q;
  assign cs_bank        = bank_q;

endmodule

// File: rtl/flash_mm_bridge.sv
module flash_mm_bridge #(
  parameter int NB     = 4,
  parameter int DATA_W = 32,
  parameter int CS_GAP = 4
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     sw_mode,
  input  logic                                     wburst_mode,
  input  logic                                     fast_mode,
  input  logic [NB-1:0]                            wel_bank,
  input  logic                                     req_valid,
  output logic                                     req_ready,
  input  logic                                     req_write,
  input  logic [24+$clog2(NB)-$clog2(DATA_W/8)-1:0] req_addr,
  input  logic [DATA_W/8-1:0]                      req_be,
  input  logic [DATA_W-1:0]                        req_wdata,
  output logic                                     rsp_valid,
  input  logic                                     rsp_ready,
  output logic [DATA_W-1:0]                        rsp_data,
  output logic                                     evt_wr_done,
  output logic                                     evt_bad_write,
  output logic                                     evt_bad_access,
  output logic                                     spi_sck,
  output logic [NB-1:0]                            spi_cs_n,
  output logic                                     spi_mosi,
  input  logic                                     spi_miso
);
  localparam int BANK_W = $clog2(NB);

  logic              sh_start, sh_busy, sh_done;
  logic [7:0]        sh_tx, sh_rx;
  logic              cs_act;
  logic [BANK_W-1:0] cs_bank;

  smb_seq #(
    .NB     (NB),
    .DATA_W (DATA_W),
    .CS_GAP (CS_GAP)
  ) i_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .sw_mode        (sw_mode),
    .wburst_mode    (wburst_mode),
    .fast_mode      (fast_mode),
    .wel_bank       (wel_bank),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_write      (req_write),
    .req_addr       (req_addr),
    .req_be         (req_be),
    .req_wdata      (req_wdata),
    .rsp_valid      (rsp_valid),
    .rsp_ready      (rsp_ready),
    .rsp_data       (rsp_data),
    .evt_wr_done    (evt_wr_done),
    .evt_bad_write  (evt_bad_write),
    .evt_bad_access (evt_bad_access),
    .sh_start       (sh_start),
    .sh_tx          (sh_tx),
    .sh_busy        (sh_busy),
    .sh_done        (sh_done),
    .sh_rx          (sh_rx),
    .cs_act         (cs_act),
    .cs_bank        (cs_bank)
  );

  smb_shift #(
    .WORD_W (8)
  ) i_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (sh_start),
    .tx_word (sh_tx),
    .miso    (spi_miso),
    .busy    (sh_busy),
    .done    (sh_done),
    .rx_word (sh_rx),
    .sck     (spi_sck),
    .mosi    (spi_mosi)
  );

  for (genvar g = 0; g < NB; g++) begin : g_cs
    assign spi_cs_n[g] = !(cs_act && (cs_bank == BANK_W'(g)));
  end

endmodule

// File: rtl/smb_chk.sv
module smb_chk #(
  parameter int NB     = 4,
  parameter int DATA_W = 32,
  parameter int CS_GAP = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NB-1:0]     spi_cs_n,
  input logic              spi_sck,
  input logic              spi_mosi,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              req_ready,
  input logic              evt_wr_done,
  input logic              evt_bad_write,
  input logic              evt_bad_access
);
  localparam int GAP_W = $clog2(CS_GAP + 1);

  logic             idle;
  logic [GAP_W-1:0] gap_cnt;

  assign idle = &spi_cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         gap_cnt <= '0;
    else if (!idle)                     gap_cnt <= '0;
    else if (gap_cnt < GAP_W'(CS_GAP))  gap_cnt <= gap_cnt + 1'b1;
  end

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~spi_cs_n) <= 1);                                   // R10
  AST_SCK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !spi_sck);                                            // R12
  AST_MOSI_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_mosi) |-> !spi_sck);                              // R12
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));   // R13
  AST_NO_TAKE_IN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);                                     // R13
  AST_DESELECT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    idle && (gap_cnt < GAP_W'(CS_GAP)) |=> idle);                  // R11
  AST_DONE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_wr_done |-> idle && !$past(idle));                         // R4
  AST_BADWR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    evt_bad_write |-> idle);                                       // R8
  AST_BADACC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    evt_bad_access |-> idle);                                      // R9

endmodule

bind flash_mm_bridge smb_chk #(
  .NB     (NB),
  .DATA_W (DATA_W),
  .CS_GAP (CS_GAP)
) i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .spi_cs_n       (spi_cs_n),
  .spi_sck        (spi_sck),
  .spi_mosi       (spi_mosi),
  .rsp_valid      (rsp_valid),
  .rsp_ready      (rsp_ready),
  .rsp_data       (rsp_data),
  .req_ready      (req_ready),
  .evt_wr_done    (evt_wr_done),
  .evt_bad_write  (evt_bad_write),
  .evt_bad_access (evt_bad_access)
);

// File: tb/test_flash_mm_bridge.sv
module test_flash_mm_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int NB     = 4;
  localparam int DATA_W = 32;
  localparam int CS_GAP = 4;
  localparam int WA_W   = 24;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sw_mode = 1'b0, wburst_mode = 1'b0, fast_mode = 1'b0;
  logic [NB-1:0]     wel_bank = 4'b0111;
  logic              req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b0;
  logic [WA_W-1:0]   req_addr = '0;
  logic [3:0]        req_be = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              req_ready, rsp_valid, evt_wr_done, evt_bad_write, evt_bad_access;
  logic [DATA_W-1:0] rsp_data;
  logic              spi_sck, spi_mosi, spi_miso;
  logic [NB-1:0]     spi_cs_n;

  always #(CLK_PERIOD / 2) clk = ~clk;

  flash_mm_bridge #(.NB(NB), .DATA_W(DATA_W), .CS_GAP(CS_GAP)) i_flash_mm_bridge (
    .clk(clk), .rst_n(rst_n), .sw_mode(sw_mode), .wburst_mode(wburst_mode),
    .fast_mode(fast_mode), .wel_bank(wel_bank), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .evt_wr_done(evt_wr_done),
    .evt_bad_write(evt_bad_write), .evt_bad_access(evt_bad_access),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // ---------------- flash model and port monitor ----------------
  wire        cs_idle = &spi_cs_n;
  int         bitc = 0, bytec = 0, nlog = 0, ntx = 0;
  logic [7:0] cap = '0;
  logic [7:0] log_b [64];
  logic [NB-1:0] last_cs = '1;
  logic [7:0] model_byte;
  int n_wd = 0, n_bw = 0, n_ba = 0, n_multi = 0, n_mosi = 0, gap = 0, min_gap = 1000;
  logic pmosi = 1'b0;

  assign model_byte = 8'h30 + 8'(bytec);
  assign spi_miso   = model_byte[3'(7 - bitc)];

  always @(posedge spi_sck) if (!cs_idle) begin
    cap = {cap[6:0], spi_mosi};
    if (bitc == 7) begin
      if (nlog < 64) log_b[nlog] = cap;
      nlog++;
    end
  end

  always @(negedge spi_sck or posedge cs_idle) begin
    if (cs_idle) begin bitc = 0; bytec = 0; end
    else if (bitc == 7) begin bitc = 0; bytec++; end
    else bitc++;
  end

  always @(negedge cs_idle) begin ntx++; last_cs = spi_cs_n; end

  always @(posedge clk) if (rst_n) begin
    if (evt_wr_done)    n_wd++;
    if (evt_bad_write)  n_bw++;
    if (evt_bad_access) n_ba++;
    if ($countones(~spi_cs_n) > 1) n_multi++;
    if (spi_mosi != pmosi && spi_sck) n_mosi++;
    pmosi = spi_mosi;
    if (cs_idle) gap++;
    else begin if (gap > 0 && gap < min_gap) min_gap = gap; gap = 0; end
  end

  // ---------------- checking ----------------
  int  n_chk = 0, n_err = 0;
  bit  finished = 1'b0;

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic chk_log(input string r, input int base, input int n, input logic [95:0] exp);
    bit ok = 1'b1;
    for (int i = 0; i < n; i++)
      if (log_b[base + i] !== exp[95 - 8*i -: 8]) ok = 1'b0;
    n_chk++;
    if (!ok || nlog - base != n) begin
      n_err++;
      $display("FAIL %s actual=%0d bytes, first %h expected=%0d bytes, first %h",
               r, nlog - base, log_b[base], n, exp[95 -: 8]);
    end
  endtask

  function automatic logic [WA_W-1:0] wa(input logic [1:0] b, input logic [23:0] fa);
    return {b, fa[23:2]};
  endfunction

  task automatic host_req(input bit wr, input logic [WA_W-1:0] a, input logic [3:0] be,
                          input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic host_read(input logic [WA_W-1:0] a, input logic [3:0] be, input string r,
                           output logic [31:0] d);
    logic [31:0] first;
    bit held = 1'b1;
    host_req(1'b0, a, be, '0);
    while (!rsp_valid) @(negedge clk);
    first = rsp_data;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (!rsp_valid || rsp_data !== first || req_ready) held = 1'b0;
    end
    chk({r, " R13 response held"}, 64'(held), 64'd1);
    rsp_ready = 1'b1;
    d = rsp_data;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic wait_log(input int target);
    for (int i = 0; i < 3000 && nlog < target; i++) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && !cs_idle; i++) @(negedge clk);
    repeat (CS_GAP + 2) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    repeat (2) @(negedge clk);
    chk("R1 cs high", 64'(spi_cs_n), 64'hF);
    chk("R1 sck low", 64'(spi_sck), 64'd0);
    chk("R1 no rsp", 64'(rsp_valid), 64'd0);
    chk("R1 no events", 64'(n_wd + n_bw + n_ba), 64'd0);
    repeat (CS_GAP + 2) @(negedge clk);
    chk("R1 ready after gap", 64'(req_ready), 64'd1);
  endtask

  task automatic t_read_plain();
    int b = nlog, t = ntx;
    logic [31:0] d;
    fast_mode = 1'b0;
    host_read(wa(2'd1, 24'h012344), 4'hF, "R2", d);
    chk_log("R2 read header", b, 8, {96'h03012344_00000000, 32'h0});
    chk("R2 read data", 64'(d), 64'h37363534);
    chk("R10 bank1 select", 64'(last_cs), 64'hD);
    chk("R2 one transaction", 64'(ntx - t), 64'd1);
  endtask

  task automatic t_read_fast();
    int b = nlog;
    logic [31:0] d;
    fast_mode = 1'b1;
    host_read(wa(2'd0, 24'h000100), 4'b0110, "R3", d);
    chk_log("R3 fast header", b, 7, {56'h0B000101_000000, 40'h0});
    chk("R3 fast data skips dummy", 64'(d), 64'h00363500);
    chk("R10 bank0 select", 64'(last_cs), 64'hE);
    fast_mode = 1'b0;
    wait_idle();
  endtask

  task automatic t_write_single();
    int b = nlog, w = n_wd;
    wburst_mode = 1'b0;
    host_req(1'b1, wa(2'd2, 24'h00A010), 4'b0011, 32'h0000BBAA);
    wait_log(b + 6);
    wait_idle();
    chk_log("R4 program bytes", b, 6, {48'h0200A010_AABB, 48'h0});
    chk("R4 write done pulse", 64'(n_wd - w), 64'd1);
    chk("R10 bank2 select", 64'(last_cs), 64'hB);
  endtask

  task automatic t_burst();
    int b = nlog, w = n_wd, t = ntx;
    wburst_mode = 1'b1;
    host_req(1'b1, wa(2'd0, 24'h000200), 4'hF, 32'h11223344);
    host_req(1'b1, wa(2'd0, 24'h000204), 4'hF, 32'h55667788);
    wait_log(b + 12);
    chk_log("R5 merged program", b, 12, 96'h02000200_44332211_88776655);
    chk("R5 cs held low", 64'(cs_idle), 64'd0);
    chk("R5 single command", 64'(ntx - t), 64'd1);
    chk("R5 no done yet", 64'(n_wd - w), 64'd0);
    host_req(1'b1, wa(2'd0, 24'h000300), 4'hF, 32'h99AABBCC);
    wait_log(b + 20);
    chk_log("R6 jump restarts", b + 12, 8, {64'h02000300_CCBBAA99, 32'h0});
    chk("R6 jump closes burst", 64'(n_wd - w), 64'd1);
    chk("R6 jump new command", 64'(ntx - t), 64'd2);
    host_req(1'b1, wa(2'd0, 24'h000304), 4'b0011, 32'h0000EEDD);
    wait_log(b + 26);
    chk_log("R6 size change restarts", b + 20, 6, {48'h02000304_DDEE, 48'h0});
    chk("R6 size change closes", 64'(n_wd - w), 64'd2);
    chk("R6 size change new command", 64'(ntx - t), 64'd3);
    chk("R7 still open", 64'(cs_idle), 64'd0);
    @(negedge clk);
    wburst_mode = 1'b0;
    wait_idle();
    chk("R7 clear closes", 64'(n_wd - w), 64'd3);
    chk("R7 cs released", 64'(cs_idle), 64'd1);
  endtask

  task automatic t_no_wel();
    int b = nlog, t = ntx, e = n_bw;
    host_req(1'b1, wa(2'd3, 24'h000040), 4'hF, 32'hDEADBEEF);
    repeat (20) @(negedge clk);
    chk("R8 bad write pulse", 64'(n_bw - e), 64'd1);
    chk("R8 no transaction", 64'(ntx - t), 64'd0);
    chk("R8 no bytes", 64'(nlog - b), 64'd0);
  endtask

  task automatic t_sw_mode();
    int b = nlog, t = ntx, e = n_ba;
    logic [31:0] d;
    sw_mode = 1'b1;
    host_read(wa(2'd1, 24'h000010), 4'hF, "R9", d);
    chk("R9 read returns zero", 64'(d), 64'd0);
    host_req(1'b1, wa(2'd0, 24'h000020), 4'hF, 32'h12345678);
    repeat (20) @(negedge clk);
    chk("R9 bad access pulses", 64'(n_ba - e), 64'd2);
    chk("R9 no transaction", 64'(ntx - t), 64'd0);
    chk("R9 no bytes", 64'(nlog - b), 64'd0);
    sw_mode = 1'b0;
  endtask

  task automatic t_port_rules();
    chk("R11 min deselect gap", 64'(min_gap >= CS_GAP), 64'd1);
    chk("R10 one select", 64'(n_multi), 64'd0);
    chk("R12 mosi in low phase", 64'(n_mosi), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_read_plain();
    t_read_fast();
    t_write_single();
    t_burst();
    t_no_wel();
    t_sw_mode();
    t_port_rules();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule